// File: doc/BRIEF.md
# Tamper zeroization controller

This controller collects tamper indications for a secure microcontroller and runs the response to them. The trigger inputs are a set of environmental sensor alarms, a die-shield breach flag, a program-integrity mismatch flag, and two external self-destruct pins. Each input passes through a two-flop synchronizer and then sets a sticky latch, so even a one-cycle glitch leaves the response armed.

There are two classes of trigger. Destructive triggers start a fixed, hardware-only sequence. It clears the key store in one cycle, then collapses the external bus and removes external memory power. It then clears each memory region in index order, using a request/done handshake, and finally asserts a destructive reset. The controller then stays locked until a battery-domain clear pulse arrives. The second self-destruct pin is the only interrupt-only trigger: it raises an interrupt and touches nothing else.

A 16-bit sticky status word records which sources fired. The memory-region handshake follows a simple rule: a request stays high, and stays on the same region, until that region's done input is sampled high. The controller never gives up on a region, so a region that never answers stalls the sequence before the reset.

Top module: `tamper_zeroize_ctrl`

## Requirements
- R1: After `rst_n` is released, the outputs sit at their idle values: `ext_mem_pwr_en`=1, and `bus_collapse`, `key_clr`, `destr_rst`, `tamper_irq`, `region_clr_req` and `status` are all 0.
- R2: The status bit positions are: bit 0 shield, bit 1 integrity, bit 2 destructive pin, bit 3 interrupt pin, bits 4 and up sensor k at 4+k; unused bits read 0. When a destructive input rises, even for one cycle, its status bit is set three cycles later. `key_clr` is high for exactly one cycle, four cycles after the input rose.
- R3: An integrity mismatch while `integ_chk_en`=0 sets no status bit and starts no response.
- R4: The cycle after `key_clr`, `bus_collapse` rises and `ext_mem_pwr_en` falls. Both hold until `bat_clr`.
- R5: Regions are cleared in ascending index order, with one request high at a time. Each request holds until that region's done input is sampled high.
- R6: `destr_rst` rises only after the last region's done, and stays high with the bus collapsed while locked.
- R7: The interrupt pin sets status bit 3 and `tamper_irq`. It does not pulse `key_clr`, collapse the bus or cut memory power.
- R8: A software write with a 1 in bit 3 clears that bit and `tamper_irq`. Writes never clear the destructive bits (0, 1, 2, 4 and up).
- R9: A destructive trigger that arrives while a sequence runs is logged in status, but it neither restarts the sequence nor pulses `key_clr` again.
- R10: A `bat_clr` pulse returns the controller to idle and clears all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low battery power-on reset |
| bat_clr | input | 1 | Battery-domain clear; unlocks and clears status |
| sensor_alarm | input | NUM_SENSORS | Environmental sensor out-of-range flags |
| shield_breach | input | 1 | Die shield breach flag |
| integ_mismatch | input | 1 | Program checksum mismatch flag |
| integ_chk_en | input | 1 | Enables integrity-mismatch triggering |
| sdi_destruct | input | 1 | External destructive self-destruct pin |
| sdi_irq | input | 1 | External interrupt-only self-destruct pin |
| region_clr_done | input | NUM_REGIONS | Per-region clear completion |
| sw_wr_en | input | 1 | Software status write strobe |
| sw_wr_data | input | 16 | Write-1-to-clear data for status |
| status | output | 16 | Sticky tamper source status |
| key_clr | output | 1 | One-cycle key store clear strobe |
| region_clr_req | output | NUM_REGIONS | Per-region clear request |
| ext_mem_pwr_en | output | 1 | External memory power enable |
| bus_collapse | output | 1 | Drives external address/data lines to collapsed level |
| destr_rst | output | 1 | Destructive reset |
| tamper_irq | output | 1 | Tamper interrupt |

## Verification
Each destructive source is fired with a single-cycle pulse: the shield, the destructive pin, a sensor at the top of the bit range, and the integrity flag with checking enabled. Each run checks that source's status bit position together with the exact cycles of the key strobe, the bus collapse, the region walk and the reset. The integrity flag is also fired with checking disabled, and the interrupt pin is fired on its own; these separate the gating and the interrupt-only class from the destructive path. A retrigger in the middle of the region walk shows that new sources are logged without a restart. A region whose done input is withheld shows that the handshake blocks the reset. Software writes of all ones separate the clearable interrupt bit from the sticky destructive bits.

// File: rtl/tzc_pkg.sv
package tzc_pkg;
  localparam int STAT_W    = 16;
  localparam int BIT_SHLD  = 0;
  localparam int BIT_INTEG = 1;
  localparam int BIT_SDI_D = 2;
  localparam int BIT_SDI_I = 3;
  localparam int BIT_SENS0 = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEYS,
    ST_BUS,
    ST_MEM,
    ST_LOCK
  } tzc_state_e;
endpackage

// File: rtl/tzc_sync_latch.sv
module tzc_sync_latch #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  input  logic en,
  input  logic w1c,
  output logic q
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= 1'b0;
    else if (clr)              q <= 1'b0;
    else if (sync_q && en)     q <= 1'b1;
    else if (w1c && !STICKY)   q <= 1'b0;
  end

  generate
    if (STICKY) begin : g_sticky_chk
      a_r8_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q)
        else $error("destructive latch dropped without battery clear");
    end
  endgenerate
endmodule

// File: rtl/tzc_trigger_bank.sv
module tzc_trigger_bank
  import tzc_pkg::*;
#(
  parameter int NUM_SENSORS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [NUM_SENSORS-1:0] sensor_alarm,
  input  logic                   shield_breach,
  input  logic                   integ_mismatch,
  input  logic                   integ_chk_en,
  input  logic                   sdi_destruct,
  input  logic                   sdi_irq,
  input  logic                   wr_en,
  input  logic [STAT_W-1:0]      wr_data,
  output logic [STAT_W-1:0]      status,
  output logic                   destr_any,
  output logic                   irq
);
  localparam int NSRC = BIT_SENS0 + NUM_SENSORS;

  logic [NSRC-1:0] src_in, src_en, lat, lat_destr;
  logic            wr_hi_unused;

  always_comb begin
    src_in = '0;
    src_in[BIT_SHLD]  = shield_breach;
    src_in[BIT_INTEG] = integ_mismatch;
    src_in[BIT_SDI_D] = sdi_destruct;
    src_in[BIT_SDI_I] = sdi_irq;
    src_in[NSRC-1:BIT_SENS0] = sensor_alarm;
    src_en = '1;
    src_en[BIT_INTEG] = integ_chk_en;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      tzc_sync_latch #(.STICKY(i != BIT_SDI_I)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .din  (src_in[i]),
        .en   (src_en[i]),
        .w1c  (wr_en & wr_data[i]),
        .q    (lat[i])
      );
    end
  endgenerate

  assign wr_hi_unused = ^wr_data[STAT_W-1:NSRC];

  always_comb begin
    status = '0;
    status[NSRC-1:0] = lat;
    lat_destr = lat;
    lat_destr[BIT_SDI_I] = 1'b0;
  end

  assign destr_any = |lat_destr;
  assign irq       = lat[BIT_SDI_I];

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[STAT_W-1:NSRC] == '0)
    else $error("reserved status bits set");
  a_r3_integ_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat[BIT_INTEG] && !integ_chk_en) |=> !lat[BIT_INTEG])
    else $error("integrity bit set while checking disabled");
endmodule

// File: rtl/tzc_zero_seq.sv
module tzc_zero_seq
  import tzc_pkg::*;
#(
  parameter int NUM_REGIONS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   trig,
  input  logic [NUM_REGIONS-1:0] done,
  output logic                   key_clr,
  output logic [NUM_REGIONS-1:0] req,
  output logic                   pwr_en,
  output logic                   collapse,
  output logic                   destr_rst
);
  localparam int              IDXW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [IDXW-1:0] LAST = IDXW'(NUM_REGIONS - 1);

  tzc_state_e      state;
  logic [IDXW-1:0] idx;
  logic            cur_done;

  always_comb begin
    cur_done = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (idx == IDXW'(i)) cur_done = done[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (clr) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trig) state <= ST_KEYS;
        ST_KEYS: state <= ST_BUS;
        ST_BUS: begin
          state <= ST_MEM;
          idx   <= '0;
        end
        ST_MEM: if (cur_done) begin
          if (idx == LAST) state <= ST_LOCK;
          else             idx   <= idx + 1'b1;
        end
        ST_LOCK: state <= ST_LOCK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign key_clr   = (state == ST_KEYS);
  assign collapse  = (state == ST_BUS) || (state == ST_MEM) || (state == ST_LOCK);
  assign pwr_en    = !collapse;
  assign destr_rst = (state == ST_LOCK);

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_req
      assign req[r] = (state == ST_MEM) && (idx == IDXW'(r));
    end
  endgenerate

  a_r2_key_single: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr |=> !key_clr)
    else $error("key clear longer than one cycle");
  a_r4_collapse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (collapse && !clr) |=> collapse)
    else $error("bus released without battery clear");
  a_r5_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req))
    else $error("more than one region request");
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(req & ~done)) && !clr) |=> $stable(req))
    else $error("region request moved before done");
  a_r6_rst_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(destr_rst) |-> $past(req[NUM_REGIONS-1] && done[NUM_REGIONS-1]))
    else $error("reset before last region done");
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (collapse && !clr) |=> !key_clr)
    else $error("sequence restarted");
endmodule

// File: rtl/tamper_zeroize_ctrl.sv
module tamper_zeroize_ctrl
  import tzc_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int NUM_REGIONS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bat_clr,
  input  logic [NUM_SENSORS-1:0] sensor_alarm,
  input  logic                   shield_breach,
  input  logic                   integ_mismatch,
  input  logic                   integ_chk_en,
  input  logic                   sdi_destruct,
  input  logic                   sdi_irq,
  input  logic [NUM_REGIONS-1:0] region_clr_done,
  input  logic                   sw_wr_en,
  input  logic [15:0]            sw_wr_data,
  output logic [15:0]            status,
  output logic                   key_clr,
  output logic [NUM_REGIONS-1:0] region_clr_req,
  output logic                   ext_mem_pwr_en,
  output logic                   bus_collapse,
  output logic                   destr_rst,
  output logic                   tamper_irq
);
  logic destr_any;

  tzc_trigger_bank #(.NUM_SENSORS(NUM_SENSORS)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (bat_clr),
    .sensor_alarm  (sensor_alarm),
    .shield_breach (shield_breach),
    .integ_mismatch(integ_mismatch),
    .integ_chk_en  (integ_chk_en),
    .sdi_destruct  (sdi_destruct),
    .sdi_irq       (sdi_irq),
    .wr_en         (sw_wr_en),
    .wr_data       (sw_wr_data),
    .status        (status),
    .destr_any     (destr_any),
    .irq           (tamper_irq)
  );

  tzc_zero_seq #(.NUM_REGIONS(NUM_REGIONS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bat_clr),
    .trig     (destr_any),
    .done     (region_clr_done),
    .key_clr  (key_clr),
    .req      (region_clr_req),
    .pwr_en   (ext_mem_pwr_en),
    .collapse (bus_collapse),
    .destr_rst(destr_rst)
  );

  a_r7_irq_not_destructive: assert property (@(posedge clk) disable iff (!rst_n)
    (!destr_any && !bus_collapse) |=> !bus_collapse)
    else $error("bus collapsed without destructive source");
endmodule

// File: tb/tamper_zeroize_ctrl_tb.sv
module tamper_zeroize_ctrl_tb;
  localparam int NS = 4;
  localparam int NR = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bat_clr = 1'b0;
  logic [NS-1:0] sensor_alarm = '0;
  logic          shield_breach = 1'b0, integ_mismatch = 1'b0, integ_chk_en = 1'b0;
  logic          sdi_destruct = 1'b0, sdi_irq = 1'b0;
  logic [NR-1:0] region_clr_done = '0;
  logic [NR-1:0] hold_mask = '0;
  logic          sw_wr_en = 1'b0;
  logic [15:0]   sw_wr_data = '0;
  logic [15:0]   status;
  logic          key_clr, ext_mem_pwr_en, bus_collapse, destr_rst, tamper_irq;
  logic [NR-1:0] region_clr_req;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tamper_zeroize_ctrl #(.NUM_SENSORS(NS), .NUM_REGIONS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bat_clr(bat_clr), .sensor_alarm(sensor_alarm),
    .shield_breach(shield_breach), .integ_mismatch(integ_mismatch),
    .integ_chk_en(integ_chk_en), .sdi_destruct(sdi_destruct), .sdi_irq(sdi_irq),
    .region_clr_done(region_clr_done), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .status(status), .key_clr(key_clr), .region_clr_req(region_clr_req),
    .ext_mem_pwr_en(ext_mem_pwr_en), .bus_collapse(bus_collapse),
    .destr_rst(destr_rst), .tamper_irq(tamper_irq)
  );

  // memory-region responder: answer one cycle after the request unless held
  always @(negedge clk) region_clr_done <= region_clr_req & ~hold_mask;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_src(input int s, input logic v);
    case (s)
      0: shield_breach = v;
      1: integ_mismatch = v;
      2: sdi_destruct = v;
      3: sdi_irq = v;
      default: sensor_alarm[s-4] = v;
    endcase
  endtask

  task automatic do_bat_clr();
    @(negedge clk); bat_clr = 1'b1;
    @(negedge clk); bat_clr = 1'b0;
    chk(ext_mem_pwr_en && !bus_collapse && !destr_rst && region_clr_req == '0, "R10 idle", {ext_mem_pwr_en, bus_collapse, destr_rst}, 3'b100);
    chk(status == 16'h0, "R10 status", status, 16'h0);
  endtask

  // one-cycle pulse on src; optional retrigger on extra (>=0) during region walk
  task automatic run_seq(input int src, input int extra);
    int keys = 0;
    @(negedge clk); drive_src(src, 1'b1);
    @(negedge clk); drive_src(src, 1'b0);
    chk(!key_clr, "R2 no early key clear", key_clr, 0);
    @(negedge clk);
    @(negedge clk);
    chk(status[src] == 1'b1, "R2 status bit", status, 32'(1) << src);
    @(negedge clk);
    chk(key_clr == 1'b1, "R2 key clear timing", key_clr, 1);
    if (key_clr) keys++;
    @(negedge clk);
    chk(!key_clr && bus_collapse && !ext_mem_pwr_en, "R4 collapse after keys", {key_clr, bus_collapse, ext_mem_pwr_en}, 3'b010);
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      chk(region_clr_req == NR'(1 << r), "R5 region order", region_clr_req, 1 << r);
      chk(!destr_rst, "R6 no early reset", destr_rst, 0);
      if (key_clr) keys++;
      if (extra >= 0 && r == 1) drive_src(extra, 1'b1);
      if (extra >= 0 && r == 2) drive_src(extra, 1'b0);
      if (extra >= 0 && r == 4) chk(status[extra] == 1'b1, "R9 retrigger logged", status, 32'(1) << extra);
    end
    @(negedge clk);
    chk(destr_rst && region_clr_req == '0, "R6 reset after last region", {destr_rst, region_clr_req}, 1 << NR);
    repeat (4) begin
      @(negedge clk);
      if (key_clr) keys++;
      chk(destr_rst && bus_collapse && !ext_mem_pwr_en, "R6 locked", {destr_rst, bus_collapse, ext_mem_pwr_en}, 3'b110);
    end
    chk(keys == 1, "R9 single key clear", keys, 1);
  endtask

  task automatic t_reset();
    chk(ext_mem_pwr_en && !bus_collapse && !key_clr && !destr_rst && !tamper_irq && region_clr_req == '0,
        "R1 reset outputs", {ext_mem_pwr_en, bus_collapse, key_clr, destr_rst, tamper_irq}, 5'b10000);
    chk(status == 16'h0, "R1 reset status", status, 0);
  endtask

  task automatic t_integ_disabled();
    bit seen = 0;
    integ_chk_en = 1'b0;
    @(negedge clk); integ_mismatch = 1'b1;
    @(negedge clk); integ_mismatch = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (key_clr || bus_collapse) seen = 1;
    end
    chk(!seen && ext_mem_pwr_en, "R3 no response when disabled", seen, 0);
    chk(status == 16'h0, "R3 no status when disabled", status, 0);
  endtask

  task automatic t_irq_only();
    bit seen = 0;
    @(negedge clk); sdi_irq = 1'b1;
    @(negedge clk); sdi_irq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(tamper_irq && status == 16'h0008, "R7 irq raised", status, 16'h0008);
    repeat (8) begin
      @(negedge clk);
      if (key_clr || bus_collapse || !ext_mem_pwr_en || destr_rst || region_clr_req != '0) seen = 1;
    end
    chk(!seen, "R7 no destructive effect", seen, 0);
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = 16'hFFFF;
    @(negedge clk); sw_wr_en = 1'b0; sw_wr_data = 16'h0;
    chk(!tamper_irq && status == 16'h0, "R8 irq bit write-1-clear", status, 0);
  endtask

  task automatic t_sticky();
    run_seq(0, -1);
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = 16'hFFFF;
    @(negedge clk); sw_wr_en = 1'b0; sw_wr_data = 16'h0;
    chk(status == 16'h0001, "R8 destructive bit sticky", status, 16'h0001);
    do_bat_clr();
  endtask

  task automatic t_stall();
    bit early = 0;
    bit done_rst = 0;
    hold_mask = NR'(1 << 2);
    @(negedge clk); sdi_destruct = 1'b1;
    @(negedge clk); sdi_destruct = 1'b0;
    repeat (7) @(negedge clk);
    chk(region_clr_req == NR'(1 << 2), "R5 stalled region", region_clr_req, 1 << 2);
    repeat (10) begin
      @(negedge clk);
      if (region_clr_req != NR'(1 << 2) || destr_rst) early = 1;
    end
    chk(!early, "R5 request held without done", early, 0);
    hold_mask = '0;
    repeat (6) begin
      @(negedge clk);
      if (destr_rst) done_rst = 1;
    end
    chk(done_rst, "R6 reset after release", done_rst, 1);
    do_bat_clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_integ_disabled();
    t_irq_only();
    t_sticky();
    run_seq(2, -1);
    do_bat_clr();
    run_seq(4 + NS - 1, -1);
    do_bat_clr();
    integ_chk_en = 1'b1;
    run_seq(1, -1);
    do_bat_clr();
    run_seq(0, 2);
    chk(status == 16'h0005, "R9 both sources logged", status, 16'h0005);
    do_bat_clr();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule